// File: doc/BRIEF.md
# 8-bit ALU with Condition-Code Flags

This block is the arithmetic and logic datapath of a small accumulator CPU. It takes two byte operands, a carry-in, a four-bit operation code and the current flags byte. In the same cycle it returns a result and the flags byte that should replace the current one. It is purely combinational. The surrounding core registers the result and the flags, and does its own instruction decode, register file and memory access.

It covers binary add and subtract with and without carry or borrow, the three bitwise logic operations, shifts and rotates through carry, 8-bit and 16-bit moves, and a decimal-adjust step. Decimal adjust turns the output of a preceding binary add of two BCD bytes into a valid BCD byte. It does this using the half-carry and carry flags that the add left behind. Moves still update the sign and zero flags, so a loaded value can be tested without a separate compare.

Top module: `alu8_ccr`

## Requirements
- R1: The flags byte has overflow V at bit 7, half-carry H at bit 4, interrupt mask I at bit 3, negative N at bit 2, zero Z at bit 1 and carry C at bit 0. For every operation, I and the unused bits 6 and 5 are copied unchanged from flags input to flags output.
- R2: Code 0 (add) and code 1 (add with carry-in) give result a+b (+cin for code 1) modulo 256. C is the carry out of bit 7, and V is set exactly when both operands share a sign that differs from the result's sign.
- R3: H is the carry from bit 3 into bit 4, and is written only by codes 0 and 1. Every other code leaves H equal to its input.
- R4: Code 2 (subtract) and code 3 (subtract with cin as borrow-in) give a-b (-cin for code 3) modulo 256. C is set when a borrow is needed, and V is set when the operand signs differ and the result's sign differs from a.
- R5: Codes 4, 5 and 6 give a AND b, a OR b and a XOR b. They clear V and keep C and H.
- R6: Code 7 shifts left with 0 in and code 8 shifts right with 0 in. Code 9 shifts right keeping bit 7. Code 10 rotates left through cin and code 11 rotates right through cin. C receives the bit shifted out, and V becomes N XOR C of the new flags.
- R7: Code 12 (byte move) outputs a, clears V and keeps C and H.
- R8: Code 13 (16-bit move) outputs {a,b} on all 16 result bits. N is bit 15, and Z is set only when all 16 bits are zero. V is cleared and C and H are kept.
- R9: For every code other than 13 and 15, the upper result byte is zero, N equals result bit 7, and Z is set exactly when the lower result byte is zero.
- R10: Code 14 (decimal adjust) adds 0x06 to a when a's low nibble exceeds 9 or H is set. It adds 0x60 when a exceeds 0x99 or C is set. C is set exactly when 0x60 was added, and V is kept. After a code-0 add of two BCD bytes, it yields the BCD sum modulo 100, with C marking a sum above 99.
- R11: Code 15 outputs result zero and passes every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand, and the high byte of a 16-bit move |
| b_i | input | 8 | Second operand, and the low byte of a 16-bit move |
| cin_i | input | 1 | Carry-in for add and rotates; borrow-in for subtract |
| flags_i | input | 8 | Current flags byte |
| result_o | output | 16 | Result; the upper byte is used only by the 16-bit move |
| flags_o | output | 8 | Next flags byte |

## Verification
The in-RTL checks assume that op_i, a_i and flags_i carry known values whenever they are evaluated, and they skip evaluation while any of these is unknown. The bench meets this assumption by driving every input from time zero and changing them only between samples. The checks also assume that a decimal adjust receives the state of a preceding binary add. The bench's BCD sweep keeps to this by always feeding the add's result and flags into the adjust step.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 4;
    localparam int RW  = 2 * DW;

    localparam int F_V = 7;
    localparam int F_H = 4;
    localparam int F_I = 3;
    localparam int F_N = 2;
    localparam int F_Z = 1;
    localparam int F_C = 0;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBC = 4'd3,
        OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_SHL = 4'd7,
        OP_SHR  = 4'd8,  OP_SAR  = 4'd9,  OP_RCL  = 4'd10, OP_RCR = 4'd11,
        OP_MV8  = 4'd12, OP_MV16 = 4'd13, OP_DADJ = 4'd14, OP_NOP = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          v;
        logic          h;
    } arith_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
    } shres_t;

    function automatic logic is_add(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC);
    endfunction

    function automatic logic clears_v(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_MV8) || (op == OP_MV16);
    endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output arith_t        out
);
    logic          use_cin;
    logic          is_sub;
    logic [DW:0]   sum;
    logic [DW:0]   diff;
    logic [NW:0]   low;

    always_comb begin
        use_cin = ((op == OP_ADC) || (op == OP_SBC)) && cin;
        is_sub  = (op == OP_SUB) || (op == OP_SBC);
        sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, use_cin};
        diff = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, use_cin};
        low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, use_cin};
        out.h = low[NW];
        if (is_sub) begin
            out.res = diff[DW-1:0];
            out.c   = diff[DW];
            out.v   = (a[DW-1] != b[DW-1]) && (diff[DW-1] != a[DW-1]);
        end else begin
            out.res = sum[DW-1:0];
            out.c   = sum[DW];
            out.v   = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output shres_t        out
);
    always_comb begin
        unique case (op)
            OP_SHL:  out = '{res: {a[DW-2:0], 1'b0},     c: a[DW-1]};
            OP_SHR:  out = '{res: {1'b0, a[DW-1:1]},     c: a[0]};
            OP_SAR:  out = '{res: {a[DW-1], a[DW-1:1]},  c: a[0]};
            OP_RCL:  out = '{res: {a[DW-2:0], cin},      c: a[DW-1]};
            OP_RCR:  out = '{res: {cin, a[DW-1:1]},      c: a[0]};
            default: out = '{res: a,                     c: 1'b0};
        endcase
    end
endmodule

// File: rtl/alu8_dadj.sv
module alu8_dadj
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          h,
    input  logic          c,
    output shres_t        out
);
    localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
    localparam logic [NW-1:0] FIX       = NW'(6);
    localparam logic [DW-1:0] BYTE_MAX  = {DIGIT_MAX, DIGIT_MAX};

    logic          fix_lo;
    logic          fix_hi;
    logic [DW-1:0] corr;

    always_comb begin
        fix_lo  = (a[NW-1:0] > DIGIT_MAX) || h;
        fix_hi  = (a > BYTE_MAX) || c;
        corr    = {fix_hi ? FIX : NW'(0), fix_lo ? FIX : NW'(0)};
        out.res = a + corr;
        out.c   = fix_hi;
    end
endmodule

// File: rtl/alu8_ccr.sv
module alu8_ccr
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic           cin_i,
    input  logic [DW-1:0]  flags_i,
    output logic [RW-1:0]  result_o,
    output logic [DW-1:0]  flags_o
);
    alu_op_e op;
    arith_t  ar;
    shres_t  sh;
    shres_t  da;

    assign op = alu_op_e'(op_i);

    alu8_arith u_arith (.op(op), .a(a_i), .b(b_i), .cin(cin_i), .out(ar));
    alu8_shift u_shift (.op(op), .a(a_i), .cin(cin_i), .out(sh));
    alu8_dadj  u_dadj  (.a(a_i), .h(flags_i[F_H]), .c(flags_i[F_C]), .out(da));

    always_comb begin
        result_o = '0;
        flags_o  = flags_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result_o[DW-1:0] = ar.res;
                flags_o[F_C]     = ar.c;
                flags_o[F_V]     = ar.v;
                if (is_add(op)) flags_o[F_H] = ar.h;
            end
            OP_AND:  result_o[DW-1:0] = a_i & b_i;
            OP_OR:   result_o[DW-1:0] = a_i | b_i;
            OP_XOR:  result_o[DW-1:0] = a_i ^ b_i;
            OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR: begin
                result_o[DW-1:0] = sh.res;
                flags_o[F_C]     = sh.c;
                flags_o[F_V]     = sh.res[DW-1] ^ sh.c;
            end
            OP_MV8:  result_o[DW-1:0] = a_i;
            OP_MV16: result_o = {a_i, b_i};
            OP_DADJ: begin
                result_o[DW-1:0] = da.res;
                flags_o[F_C]     = da.c;
            end
            default: ;
        endcase
        if (clears_v(op)) flags_o[F_V] = 1'b0;
        if (op == OP_MV16) begin
            flags_o[F_N] = result_o[RW-1];
            flags_o[F_Z] = (result_o == '0);
        end else if (op != OP_NOP) begin
            flags_o[F_N] = result_o[DW-1];
            flags_o[F_Z] = (result_o[DW-1:0] == '0);
        end
    end

    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, cin_i, flags_i})) begin
            p_imask_pass_r1: assert (flags_o[F_I] == flags_i[F_I] &&
                                     flags_o[6:5] == flags_i[6:5])
                else $error("I or reserved flag bits altered");
            p_hc_kept_r3: assert (is_add(op) || flags_o[F_H] == flags_i[F_H])
                else $error("half-carry written by non-add op");
            p_sub_borrow_r4: assert (op != OP_SUB || flags_o[F_C] == (a_i < b_i))
                else $error("subtract borrow mismatch");
            p_no_overflow_r5: assert (!clears_v(op) || !flags_o[F_V])
                else $error("overflow not cleared");
            p_mv8_zero_r7: assert (op != OP_MV8 || flags_o[F_Z] == (a_i == '0))
                else $error("byte move zero flag mismatch");
            p_mv16_neg_r8: assert (op != OP_MV16 || flags_o[F_N] == a_i[DW-1])
                else $error("16-bit move negative flag mismatch");
            p_upper_zero_r9: assert (op == OP_MV16 || result_o[RW-1:DW] == '0)
                else $error("upper result byte not zero");
            p_nop_hold_r11: assert (op != OP_NOP || (flags_o == flags_i && result_o == '0))
                else $error("no-op changed state");
        end
    end
endmodule

// File: tb/tb_alu8_ccr.sv
module tb_alu8_ccr;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  a;
        logic [7:0]  b;
        logic        cin;
        logic [7:0]  fl;
        logic [15:0] res;
        logic [7:0]  flo;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h02},
        '{4'd0,  8'h7F, 8'h01, 1'b0, 8'h08, 16'h0080, 8'h9C},
        '{4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 16'h0000, 8'h13},
        '{4'd1,  8'h10, 8'h20, 1'b1, 8'h08, 16'h0031, 8'h08},
        '{4'd2,  8'h05, 8'h06, 1'b0, 8'h18, 16'h00FF, 8'h1D},
        '{4'd3,  8'h80, 8'h01, 1'b1, 8'h00, 16'h007E, 8'h80},
        '{4'd4,  8'hF0, 8'h3C, 1'b0, 8'h91, 16'h0030, 8'h11},
        '{4'd5,  8'h00, 8'h00, 1'b0, 8'h80, 16'h0000, 8'h02},
        '{4'd6,  8'hAA, 8'h55, 1'b0, 8'h00, 16'h00FF, 8'h04},
        '{4'd7,  8'h81, 8'h00, 1'b0, 8'h00, 16'h0002, 8'h81},
        '{4'd8,  8'h01, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h83},
        '{4'd9,  8'h81, 8'h00, 1'b0, 8'h00, 16'h00C0, 8'h05},
        '{4'd10, 8'h40, 8'h00, 1'b1, 8'h00, 16'h0081, 8'h84},
        '{4'd11, 8'h01, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h83},
        '{4'd12, 8'h80, 8'h00, 1'b0, 8'h91, 16'h0080, 8'h15},
        '{4'd13, 8'h00, 8'h01, 1'b0, 8'h00, 16'h0001, 8'h00},
        '{4'd13, 8'h00, 8'h00, 1'b0, 8'h08, 16'h0000, 8'h0A},
        '{4'd14, 8'h3C, 8'h00, 1'b0, 8'h00, 16'h0042, 8'h00},
        '{4'd14, 8'h9A, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h03},
        '{4'd14, 8'h12, 8'h00, 1'b0, 8'h11, 16'h0078, 8'h11},
        '{4'd15, 8'h55, 8'h33, 1'b1, 8'hE9, 16'h0000, 8'hE9},
        '{4'd0,  8'h01, 8'h01, 1'b0, 8'h60, 16'h0002, 8'h60}
    };

    logic        clk = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic        cin_i = 1'b0;
    logic [7:0]  flags_i = '0;
    logic [15:0] result_o;
    logic [7:0]  flags_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu8_ccr dut (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
    );

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2/R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5, 4'd6: return "R5";
            4'd7, 4'd8, 4'd9, 4'd10, 4'd11: return "R6";
            4'd12: return "R7";
            4'd13: return "R8";
            4'd14: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b,
                         logic cin, logic [7:0] fl);
        op_i = op; a_i = a; b_i = b; cin_i = cin; flags_i = fl;
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2;
        // initial state with all-zero inputs: R9 zero flag on a zero add
        check("R9", "idle result", result_o, 16'h0000);
        check("R9", "idle flags", {8'h00, flags_o}, 16'h0002);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].cin, VEC[i].fl);
            check(req_of(VEC[i].op), "result", result_o, VEC[i].res);
            check(req_of(VEC[i].op), "flags", {8'h00, flags_o}, {8'h00, VEC[i].flo});
        end

        // R1: I and bits 6..5 pass through on every op
        for (int op = 0; op < 16; op++) begin
            apply(4'(op), 8'hA5, 8'h5A, 1'b1, 8'h68);
            check("R1", "I/reserved passthrough", {13'd0, flags_o[6:5], flags_o[3]}, 16'h0007);
        end

        // R3: H kept on a subtract that would carry from bit 3
        apply(4'd2, 8'h0F, 8'hF1, 1'b0, 8'h00);
        check("R3", "H kept on subtract", {15'd0, flags_o[4]}, 16'h0000);

        // R9: negative and zero follow the low byte across 8-bit ops
        apply(4'd6, 8'h80, 8'h00, 1'b0, 8'h06);
        check("R9", "N set Z clear on xor", {14'd0, flags_o[2:1]}, 16'h0002);

        // R10: BCD add then decimal adjust over every digit pair
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                logic [7:0] sum_r;
                logic [7:0] fl_r;
                int s;
                apply(4'd0, 8'((x / 10) * 16 + x % 10), 8'((y / 10) * 16 + y % 10), 1'b0, 8'h00);
                sum_r = result_o[7:0];
                fl_r  = flags_o;
                apply(4'd14, sum_r, 8'h00, 1'b0, fl_r);
                s = (x + y) % 100;
                check("R10", "BCD sum", {7'd0, flags_o[0], result_o[7:0]},
                      {7'd0, (x + y) > 99, 8'((s / 10) * 16 + s % 10)});
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule